// File: doc/BRIEF.md
# Linked-List DMA Descriptor Sequencer

This block is the control engine of a single DMA channel that works through a chain of transfer descriptors held in memory. Software gives the channel the address of the first descriptor and pulses a start input. From then on the block reads each four-word descriptor over a word-wide read port. It then issues the transfer it describes as a run of single-item requests grouped into bursts, and follows the link word to the next descriptor without help. A link word whose address bits above the 16-byte alignment are all zero marks the final descriptor. Once that descriptor's data has moved, the channel drops its busy flag.

Each descriptor occupies four consecutive words at a 16-byte boundary: the source start address, the destination address, the link to the next descriptor and a control word. The control word gives the item count, the item width and separate source and destination burst codes. The source address advances by the item width after every item, and the destination address is held, as for a peripheral data register. A one-cycle terminal-count pulse marks the completion of every descriptor. Any error reported by either port stops the channel at once and raises a one-cycle error pulse.

Top module: `ll_dma_seq`

## Requirements
- R1: After reset, and whenever the channel is idle, `busy`, `mr_req`, `dp_valid`, `tc_pulse` and `err_pulse` are all low.
- R2: A `start` pulse while idle makes the channel read the descriptor at `start_addr` with its low four bits forced to zero. It reads one word per `mr_valid` response, at offsets 0, 4, 8 and 12 in that order, taking them as source address, destination address, link and control word. `mr_req` and `dp_valid` are never high together.
- R3: Each data item request presents the current source and destination addresses. The destination stays equal to the descriptor's destination word. The source starts at the descriptor's source word and grows after each accepted item by 1, 2 or 4 bytes for width code 0, 1 or 2 in control bits [19:18], and by 4 bytes for code 3.
- R4: Exactly as many items are requested as control bits [11:0] give. A count of zero moves no data.
- R5: The burst length is 2 raised to the smaller of the source burst code (control bits [14:12]) and the destination burst code (control bits [17:15]). `dp_first` marks the first item of each burst. `dp_last` marks its final item, or the final item of the descriptor when fewer items remain than a full burst.
- R6: `tc_pulse` is high for exactly the one cycle after the final item of a descriptor is accepted. For a zero-count descriptor it is high for the one cycle after its control word is returned.
- R7: When the link word's bits [31:4] are non-zero, the channel requests the first word of the linked descriptor in the cycle after `tc_pulse`.
- R8: When the link word's bits [31:4] are zero, `busy` is low and no read is requested in the cycle after `tc_pulse`.
- R9: An item accepted with `dp_err` high raises `err_pulse` in the next cycle for one cycle, after which the channel is idle. No further items or descriptor reads follow.
- R10: A descriptor word returned with `mr_err` high raises `err_pulse` in the next cycle for one cycle, after which the channel is idle. No further reads or items follow.
- R11: A `start` pulse while `busy` is high has no effect on the reads or items that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a chain at `start_addr` (only while idle) |
| start_addr | input | 32 | Address of the first descriptor |
| busy | output | 1 | Channel enabled and working through a chain |
| tc_pulse | output | 1 | One-cycle terminal-count event per finished descriptor |
| err_pulse | output | 1 | One-cycle event when a port reports an error |
| mr_req | output | 1 | Descriptor word read request, held until answered |
| mr_addr | output | 32 | Address of the requested descriptor word |
| mr_valid | input | 1 | Read response for the current request |
| mr_rdata | input | 32 | Returned descriptor word |
| mr_err | input | 1 | Read response carries an error |
| dp_valid | output | 1 | Data item request |
| dp_src | output | 32 | Source address of the item |
| dp_dst | output | 32 | Destination address of the item |
| dp_first | output | 1 | Item opens a burst |
| dp_last | output | 1 | Item closes a burst |
| dp_ready | input | 1 | Data port accepts the item this cycle |
| dp_err | input | 1 | Accepted item failed on the bus |

## Verification
The properties assume that `mr_valid` and `dp_ready` are only raised while the matching request is high. They also assume that `mr_err` and `dp_err` appear only together with those responses, and that descriptor chains stay inside the addressed memory. The stimulus answers reads and items only when a request is pending, with response gaps from a pseudo-random sequence. It raises an error flag only on one chosen response in the error cases, and it places every descriptor, including a zero-count one, in the bench memory model before the chain starts.

// File: rtl/ll_dma_pkg.sv
package ll_dma_pkg;

    localparam int WORD_W      = 32;
    localparam int DESC_WORDS  = 4;
    localparam int IDX_W       = $clog2(DESC_WORDS);
    localparam int BYTE_SEL_W  = $clog2(WORD_W / 8);
    localparam int ALIGN_BITS  = IDX_W + BYTE_SEL_W;

    localparam int LEN_W       = 12;
    localparam int LEN_LSB     = 0;
    localparam int CODE_W      = 3;
    localparam int SBURST_LSB  = 12;
    localparam int DBURST_LSB  = 15;
    localparam int WIDTH_W     = 2;
    localparam int WIDTH_LSB   = 18;
    localparam int BEAT_W      = (1 << CODE_W) / 8 + 7;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_FETCH,
        SQ_MOVE,
        SQ_END,
        SQ_FAULT
    } sq_state_e;

    typedef struct packed {
        logic [WORD_W-1:0]  src;
        logic [WORD_W-1:0]  dst;
        logic [WORD_W-1:0]  link;
        logic [LEN_W-1:0]   len;
        logic [CODE_W-1:0]  burst_code;
        logic [WIDTH_W-1:0] width_code;
    } desc_t;

    function automatic logic [CODE_W-1:0] min_code(input logic [CODE_W-1:0] a,
                                                   input logic [CODE_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [WORD_W-1:0] step_of(input logic [WIDTH_W-1:0] w);
        logic [WORD_W-1:0] s;
        case (w)
            2'd0:    s = WORD_W'(1);
            2'd1:    s = WORD_W'(2);
            default: s = WORD_W'(4);
        endcase
        return s;
    endfunction

    function automatic logic [BEAT_W-1:0] burst_last_beat(input logic [CODE_W-1:0] c);
        logic [BEAT_W:0] n;
        n = (BEAT_W+1)'(1) << c;
        return BEAT_W'(n - 1'b1);
    endfunction

endpackage

// File: rtl/ll_dma_fetch.sv
module ll_dma_fetch
    import ll_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] load_addr,
    output logic              mr_req,
    output logic [WORD_W-1:0] mr_addr,
    input  logic              mr_valid,
    input  logic [WORD_W-1:0] mr_rdata,
    input  logic              mr_err,
    output logic              done,
    output logic              fault,
    output desc_t             desc
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

    logic                         active;
    logic [WORD_W-1:ALIGN_BITS]   base;
    logic [IDX_W-1:0]             idx;
    logic [WORD_W-1:0]            src_q;
    logic [WORD_W-1:0]            dst_q;
    logic [WORD_W-1:0]            link_q;
    logic                         take;

    assign take   = active && mr_valid;
    assign mr_req = active;
    assign mr_addr = {base, idx, {BYTE_SEL_W{1'b0}}};
    assign done   = take && !mr_err && (idx == LAST_IDX);
    assign fault  = take && mr_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            base   <= '0;
            idx    <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            link_q <= '0;
        end else if (load) begin
            active <= 1'b1;
            base   <= load_addr[WORD_W-1:ALIGN_BITS];
            idx    <= '0;
        end else if (take) begin
            if (mr_err) begin
                active <= 1'b0;
            end else begin
                case (idx)
                    IDX_W'(0): src_q  <= mr_rdata;
                    IDX_W'(1): dst_q  <= mr_rdata;
                    IDX_W'(2): link_q <= mr_rdata;
                    default: ;
                endcase
                if (idx == LAST_IDX) active <= 1'b0;
                idx <= idx + 1'b1;
            end
        end
    end

    // The control word is the last one read, so its fields are decoded
    // straight from the response and handed over in the same cycle.
    always_comb begin
        desc.src        = src_q;
        desc.dst        = dst_q;
        desc.link       = link_q;
        desc.len        = mr_rdata[LEN_LSB +: LEN_W];
        desc.burst_code = min_code(mr_rdata[SBURST_LSB +: CODE_W],
                                   mr_rdata[DBURST_LSB +: CODE_W]);
        desc.width_code = mr_rdata[WIDTH_LSB +: WIDTH_W];
    end

endmodule

// File: rtl/ll_dma_mover.sv
module ll_dma_mover
    import ll_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  desc_t             desc,
    output logic              dp_valid,
    output logic [WORD_W-1:0] dp_src,
    output logic [WORD_W-1:0] dp_dst,
    output logic              dp_first,
    output logic              dp_last,
    input  logic              dp_ready,
    input  logic              dp_err,
    output logic              done,
    output logic              fault
);

    logic                active;
    logic [WORD_W-1:0]   src_q;
    logic [WORD_W-1:0]   dst_q;
    logic [LEN_W-1:0]    left;
    logic [BEAT_W-1:0]   beat;
    logic [CODE_W-1:0]   code_q;
    logic [WIDTH_W-1:0]  wcode_q;
    logic                fire;
    logic                final_item;
    logic                burst_end;

    assign fire       = active && dp_ready;
    assign final_item = (left == LEN_W'(1));
    assign burst_end  = (beat == burst_last_beat(code_q));

    assign dp_valid = active;
    assign dp_src   = src_q;
    assign dp_dst   = dst_q;
    assign dp_first = (beat == '0);
    assign dp_last  = burst_end || final_item;
    assign done     = fire && !dp_err && final_item;
    assign fault    = fire && dp_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            src_q   <= '0;
            dst_q   <= '0;
            left    <= '0;
            beat    <= '0;
            code_q  <= '0;
            wcode_q <= '0;
        end else if (load) begin
            active  <= (desc.len != '0);
            src_q   <= desc.src;
            dst_q   <= desc.dst;
            left    <= desc.len;
            beat    <= '0;
            code_q  <= desc.burst_code;
            wcode_q <= desc.width_code;
        end else if (fire) begin
            if (dp_err) begin
                active <= 1'b0;
            end else begin
                src_q <= src_q + step_of(wcode_q);
                left  <= left - 1'b1;
                beat  <= dp_last ? '0 : beat + 1'b1;
                if (final_item) active <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ll_dma_seq.sv
module ll_dma_seq
    import ll_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] start_addr,
    output logic              busy,
    output logic              tc_pulse,
    output logic              err_pulse,
    output logic              mr_req,
    output logic [WORD_W-1:0] mr_addr,
    input  logic              mr_valid,
    input  logic [WORD_W-1:0] mr_rdata,
    input  logic              mr_err,
    output logic              dp_valid,
    output logic [WORD_W-1:0] dp_src,
    output logic [WORD_W-1:0] dp_dst,
    output logic              dp_first,
    output logic              dp_last,
    input  logic              dp_ready,
    input  logic              dp_err
);

    sq_state_e          state, state_nx;
    logic [WORD_W-1:0]  link_q;
    logic               f_load;
    logic [WORD_W-1:0]  f_addr;
    logic               f_done;
    logic               f_fault;
    desc_t              f_desc;
    logic               m_load;
    logic               m_done;
    logic               m_fault;
    logic               link_end;

    assign link_end = (link_q[WORD_W-1:ALIGN_BITS] == '0);

    ll_dma_fetch u_fetch (
        .clk       (clk),
        .rst       (rst),
        .load      (f_load),
        .load_addr (f_addr),
        .mr_req    (mr_req),
        .mr_addr   (mr_addr),
        .mr_valid  (mr_valid),
        .mr_rdata  (mr_rdata),
        .mr_err    (mr_err),
        .done      (f_done),
        .fault     (f_fault),
        .desc      (f_desc)
    );

    ll_dma_mover u_mover (
        .clk      (clk),
        .rst      (rst),
        .load     (m_load),
        .desc     (f_desc),
        .dp_valid (dp_valid),
        .dp_src   (dp_src),
        .dp_dst   (dp_dst),
        .dp_first (dp_first),
        .dp_last  (dp_last),
        .dp_ready (dp_ready),
        .dp_err   (dp_err),
        .done     (m_done),
        .fault    (m_fault)
    );

    always_comb begin
        state_nx = state;
        f_load   = 1'b0;
        f_addr   = start_addr;
        m_load   = 1'b0;
        case (state)
            SQ_IDLE: begin
                if (start) begin
                    f_load   = 1'b1;
                    state_nx = SQ_FETCH;
                end
            end
            SQ_FETCH: begin
                if (f_fault) begin
                    state_nx = SQ_FAULT;
                end else if (f_done) begin
                    m_load   = 1'b1;
                    state_nx = (f_desc.len == '0) ? SQ_END : SQ_MOVE;
                end
            end
            SQ_MOVE: begin
                if (m_fault)     state_nx = SQ_FAULT;
                else if (m_done) state_nx = SQ_END;
            end
            SQ_END: begin
                if (link_end) begin
                    state_nx = SQ_IDLE;
                end else begin
                    f_load   = 1'b1;
                    f_addr   = link_q;
                    state_nx = SQ_FETCH;
                end
            end
            default: state_nx = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            link_q <= '0;
        end else begin
            state <= state_nx;
            if (f_done) link_q <= f_desc.link;
        end
    end

    assign busy      = (state != SQ_IDLE);
    assign tc_pulse  = (state == SQ_END);
    assign err_pulse = (state == SQ_FAULT);

endmodule

// File: rtl/ll_dma_seq_chk.sv
module ll_dma_seq_chk
    import ll_dma_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              tc_pulse,
    input logic              err_pulse,
    input logic              mr_req,
    input logic [WORD_W-1:0] mr_addr,
    input logic              mr_valid,
    input logic              mr_err,
    input logic              dp_valid,
    input logic [WORD_W-1:0] dp_dst,
    input logic              dp_ready,
    input logic              dp_err
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mr_req && !dp_valid && !tc_pulse && !err_pulse)); // R1

    AST_PORTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(mr_req && dp_valid)); // R2

    AST_FETCH_ORDER: assert property (@(posedge clk) disable iff (rst)
        (mr_req && mr_valid && !mr_err && (mr_addr[3:2] != 2'b11))
        |=> (mr_req && (mr_addr == $past(mr_addr) + 32'd4))); // R2

    AST_DST_HELD: assert property (@(posedge clk) disable iff (rst)
        (dp_valid && dp_ready && !dp_err)
        |=> (!dp_valid || (dp_dst == $past(dp_dst)))); // R3

    AST_TC_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tc_pulse |=> !tc_pulse); // R6

    AST_DATA_ERR_RAISED: assert property (@(posedge clk) disable iff (rst)
        (dp_valid && dp_ready && dp_err) |=> err_pulse); // R9

    AST_READ_ERR_RAISED: assert property (@(posedge clk) disable iff (rst)
        (mr_req && mr_valid && mr_err) |=> err_pulse); // R10

    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (rst)
        err_pulse |=> (!busy && !mr_req && !dp_valid)); // R9

endmodule

bind ll_dma_seq ll_dma_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .tc_pulse  (tc_pulse),
    .err_pulse (err_pulse),
    .mr_req    (mr_req),
    .mr_addr   (mr_addr),
    .mr_valid  (mr_valid),
    .mr_err    (mr_err),
    .dp_valid  (dp_valid),
    .dp_dst    (dp_dst),
    .dp_ready  (dp_ready),
    .dp_err    (dp_err)
);

// File: tb/sim_ll_dma_seq.sv
`timescale 1ns/1ps
module sim_ll_dma_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic        busy, tc_pulse, err_pulse;
    logic        mr_req;
    logic [31:0] mr_addr;
    logic        mr_valid = 1'b0;
    logic [31:0] mr_rdata = '0;
    logic        mr_err = 1'b0;
    logic        dp_valid;
    logic [31:0] dp_src, dp_dst;
    logic        dp_first, dp_last;
    logic        dp_ready = 1'b0;
    logic        dp_err = 1'b0;

    always #2 clk = ~clk;

    ll_dma_seq u0 (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .busy(busy), .tc_pulse(tc_pulse), .err_pulse(err_pulse),
        .mr_req(mr_req), .mr_addr(mr_addr), .mr_valid(mr_valid),
        .mr_rdata(mr_rdata), .mr_err(mr_err),
        .dp_valid(dp_valid), .dp_src(dp_src), .dp_dst(dp_dst),
        .dp_first(dp_first), .dp_last(dp_last),
        .dp_ready(dp_ready), .dp_err(dp_err)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        tcz;
        logic        fin;
    } fe_t;

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic        first;
        logic        last;
        logic        eod;
        logic        fin;
    } it_t;

    logic [31:0] mem [0:63];
    fe_t  fetchq [$];
    it_t  itemq  [$];
    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: got cycle %0d expected completion", cyc);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // Place a descriptor in memory and append what the channel must do with it.
    task automatic add_desc(input int a, input logic [31:0] s, input logic [31:0] d,
                            input logic [31:0] n, input int len, input int w,
                            input int sb, input int db);
        int blen, stp;
        logic fin;
        fin = (n[31:4] == 28'd0);
        mem[a/4]     = s;
        mem[a/4 + 1] = d;
        mem[a/4 + 2] = n;
        mem[a/4 + 3] = 32'(len) | (32'(sb) << 12) | (32'(db) << 15) | (32'(w) << 18);
        for (int k = 0; k < 4; k++)
            fetchq.push_back('{addr: 32'(a + 4*k), tcz: (k == 3 && len == 0), fin: fin});
        blen = 1 << ((sb < db) ? sb : db);
        stp  = (w >= 2) ? 4 : (1 << w);
        for (int i = 0; i < len; i++)
            itemq.push_back('{src: s + 32'(i*stp), dst: d,
                              first: ((i % blen) == 0),
                              last: ((i % blen) == blen-1) || (i == len-1),
                              eod: (i == len-1), fin: fin});
    endtask

    task automatic quiet_check(input string req);
        chk(!busy && !mr_req && !dp_valid && !tc_pulse && !err_pulse, req,
            "idle outputs {busy,mr_req,dp_valid,tc,err}",
            {27'd0, busy, mr_req, dp_valid, tc_pulse, err_pulse}, 32'd0);
    endtask

    task automatic run(input logic [31:0] a, input int ign, input int dperr, input int mrerr);
        int nitem, nfetch;
        bit tc_due, pend_fin, fin_due, nf_due, err_due, post_err, done_ok;
        bit prev_tc;
        string ereq;
        fe_t fe;
        it_t it;
        nitem = 0; nfetch = 0; tc_due = 0; pend_fin = 0; fin_due = 0; nf_due = 0;
        err_due = 0; post_err = 0; done_ok = 0; ereq = "R9";
        start = 1'b1; start_addr = a;
        @(negedge clk);
        for (int c = 0; c < 3000; c++) begin
            // compare outputs settled after the last edge
            chk(tc_pulse == tc_due, "R6", "tc_pulse", 32'(tc_pulse), 32'(tc_due));
            chk(err_pulse == err_due, ereq, "err_pulse", 32'(err_pulse), 32'(err_due));
            if (fin_due)
                chk(!busy && !mr_req, "R8", "busy/mr_req after final tc",
                    {30'd0, busy, mr_req}, 32'd0);
            if (nf_due)
                chk(mr_req && fetchq.size() > 0 && mr_addr == fetchq[0].addr, "R7",
                    "next descriptor read address", mr_addr,
                    (fetchq.size() > 0) ? fetchq[0].addr : 32'hFFFF_FFFF);
            if (post_err)
                chk(!busy && !mr_req && !dp_valid, ereq, "state after error",
                    {29'd0, busy, mr_req, dp_valid}, 32'd0);
            prev_tc  = tc_due;
            fin_due  = prev_tc && pend_fin;
            nf_due   = prev_tc && !pend_fin;
            post_err = err_due;
            err_due  = 0;
            tc_due   = 0;
            // drive inputs for the next edge
            start = 1'b0; mr_valid = 1'b0; mr_err = 1'b0; dp_ready = 1'b0; dp_err = 1'b0;
            if (c == ign) begin
                start = 1'b1; start_addr = 32'h80;
            end
            if (mr_req && lfsr[1:0] != 2'b00) begin
                if (fetchq.size() == 0) begin
                    chk(0, "R8", "unexpected descriptor read", mr_addr, 32'd0);
                end else begin
                    fe = fetchq.pop_front();
                    chk(mr_addr == fe.addr, "R2", "descriptor word address", mr_addr, fe.addr);
                    mr_valid = 1'b1;
                    mr_rdata = mem[mr_addr[7:2]];
                    nfetch++;
                    if (nfetch == mrerr) begin
                        mr_err = 1'b1; err_due = 1; ereq = "R10";
                        fetchq.delete(); itemq.delete();
                    end else if (fe.tcz) begin
                        tc_due = 1; pend_fin = fe.fin;
                    end
                end
            end
            if (dp_valid && (lfsr[2] || lfsr[3])) begin
                if (itemq.size() == 0) begin
                    chk(0, "R4", "unexpected data item", dp_src, 32'd0);
                end else begin
                    it = itemq.pop_front();
                    chk(dp_src == it.src, "R3", "item source", dp_src, it.src);
                    chk(dp_dst == it.dst, "R3", "item destination", dp_dst, it.dst);
                    chk(dp_first == it.first, "R5", "burst first flag", 32'(dp_first), 32'(it.first));
                    chk(dp_last == it.last, "R5", "burst last flag", 32'(dp_last), 32'(it.last));
                    dp_ready = 1'b1;
                    nitem++;
                    if (nitem == dperr) begin
                        dp_err = 1'b1; err_due = 1; ereq = "R9";
                        fetchq.delete(); itemq.delete();
                    end else if (it.eod) begin
                        tc_due = 1; pend_fin = it.fin;
                    end
                end
            end
            if (c > ign && fetchq.size() == 0 && itemq.size() == 0 && !busy && !tc_due &&
                !err_due && !post_err && !fin_due && !nf_due && !mr_req && !dp_valid) begin
                done_ok = 1;
                break;
            end
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end
        chk(done_ok, "R4", "chain completed with all items and reads",
            32'(itemq.size() + fetchq.size()), 32'd0);
        fetchq.delete(); itemq.delete();
        for (int q = 0; q < 3; q++) begin
            @(negedge clk);
            quiet_check("R1");
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        quiet_check("R1");

        // R2 R3 R5 R7: three linked word descriptors, last burst shortened, low start bits ignored
        add_desc(32'h40, 32'h1000, 32'hF000_0000, 32'h50, 20, 2, 4, 4);
        add_desc(32'h50, 32'h2000, 32'hF000_0000, 32'h60, 16, 2, 4, 5);
        add_desc(32'h60, 32'h3000, 32'hF000_0000, 32'h0,   5, 2, 4, 4);
        run(32'h4C, -1, 0, 0);

        // R3 R4 R5 R6: byte and halfword widths, mixed burst codes, zero-count descriptor
        add_desc(32'h70, 32'h2001, 32'hF000_0010, 32'h90, 7, 0, 2, 3);
        add_desc(32'h90, 32'h5000, 32'hF000_0020, 32'hA0, 0, 2, 1, 1);
        add_desc(32'hA0, 32'h3002, 32'hF000_0030, 32'h0,  6, 1, 1, 1);
        run(32'h70, -1, 0, 0);

        // R11: start pulse during a busy chain, single-item bursts
        add_desc(32'hB0, 32'h4000, 32'hF000_0040, 32'h0, 3, 2, 0, 0);
        run(32'hB0, 2, 0, 0);

        // R9: data error on the fifth item, linked descriptor never read
        add_desc(32'hC0, 32'h6000, 32'hF000_0050, 32'hD0, 10, 2, 2, 2);
        add_desc(32'hD0, 32'h7000, 32'hF000_0050, 32'h0,   4, 2, 2, 2);
        run(32'hC0, -1, 5, 0);

        // R10: read error on the second word of the linked descriptor
        add_desc(32'hE0, 32'h8000, 32'hF000_0060, 32'hF0, 2, 2, 0, 0);
        add_desc(32'hF0, 32'h9000, 32'hF000_0060, 32'h0,  2, 2, 0, 0);
        run(32'hE0, -1, 0, 6);

        summary();
    end

endmodule